// File: doc/BRIEF.md
# Addressable RGB LED Serial Encoder

This block converts a stream of colour bytes into the single-wire, pulse-width-coded waveform that drives a daisy chain of addressable RGB LEDs. Each bit occupies one fixed slot. A slot starts with a high pulse, short for a zero and long for a one, and ends low. The slot length and both pulse lengths are worked out at elaboration time from the system clock frequency. Each high time is rounded to a whole number of clock cycles.

A frame begins when the block is idle and receives a start strobe with a non-zero byte count. The block then pulls the bytes one at a time from an upstream source over a valid/ready handshake, keeping one byte in a prefetch buffer. The first slot of the frame is held low. The data slots follow, then a few low padding slots, then a long low latch interval that tells the LEDs to display the colours. The same latch interval also runs once after reset, before the block first reports idle. If the source does not deliver a byte in time, zero bits are sent in its place, the frame still runs to completion, and an underrun flag is raised.

Top module: `ws_led_encoder`

## Requirements
- R1: While reset is asserted, `busy_o`=1, `tx_active_o`=0, `serial_o`=0 and `underrun_o`=0. After reset is released, the block passes through one blanking interval of LATCH cycles. `busy_o` first reads 0 after LATCH+1 rising clock edges.
- R2: The bit slot length is BIT = round(CLK_HZ/800000) cycles, which is 63 at 50 MHz. Within a frame, consecutive rising edges of `serial_o` are exactly BIT cycles apart.
- R3: A zero bit is high for T0 cycles and a one bit for T1 cycles, then low for the rest of the slot. Tx = round(round(f*800000)*BIT/800000), with f = 0.32 for a zero bit and 0.64 for a one bit. This gives T0=20 and T1=40 at 50 MHz.
- R4: Each byte is sent as 8 slots, most significant bit first, and the bytes go out in the order they were accepted. A frame of N bytes contains exactly 8N high pulses.
- R5: The first slot after a start is accepted is low. `serial_o` first goes high BIT+1 cycles after the accepting edge, because the output is registered.
- R6: After the last data slot, PAD_SLOTS low slots follow, and then a low latch interval of LATCH = CLK_HZ/20000 + 2 cycles (2502 at 50 MHz). `tx_active_o` falls (1+8N+PAD_SLOTS)*BIT edges after the accepting edge, and `busy_o` falls LATCH edges after that.
- R7: `busy_o` is 1 in every state except idle. `tx_active_o` is 1 only while a frame's lead, data or padding slots are running.
- R8: A start strobe with a byte count of zero is ignored: the block stays idle, and `byte_ready_o` and `serial_o` stay 0.
- R9: A start strobe is accepted only in idle. A strobe during a frame changes neither the frame's length nor its timing.
- R10: Bytes move only on cycles where `byte_valid_i` and `byte_ready_o` are both 1, at most one per handshake. `byte_ready_o` drops in the cycle after each transfer. Exactly N bytes are requested per frame, and a byte may be offered as soon as the frame starts.
- R11: If no byte is buffered when a byte's first slot begins, eight zero bits are sent in its place and `underrun_o` is set. `underrun_o` stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start strobe, sampled in idle |
| byte_count_i | input | CNT_W | Number of bytes in the frame |
| byte_valid_i | input | 1 | Upstream byte is valid |
| byte_data_i | input | 8 | Upstream colour byte |
| byte_ready_o | output | 1 | Block takes the offered byte this cycle |
| busy_o | output | 1 | Not idle |
| tx_active_o | output | 1 | Lead, data or padding slots running |
| underrun_o | output | 1 | A byte was missing in the current or last frame |
| serial_o | output | 1 | Pulse-width-coded LED data line |

## Verification
The frames vary byte content, length and source behaviour. Content runs from all-ones through all-zeros to mixed and single-bit-set bytes, which separates the zero and one pulse widths and shows whether bit order is reversed within a byte. Frames of one, two and three bytes check the byte order, the pulse count and where the padding and latch timing falls. Some frames have every byte supplied, some have none and some only a partial set, so a correct frame can be told apart from zero-filling on underrun and from a flag that fails to clear. Every frame also gets a stray start strobe partway through, and a zero-count strobe is given in idle.

// File: rtl/ws_enc_pkg.sv
package ws_enc_pkg;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_BLANK  = 3'd1,
    ST_IDLE   = 3'd2,
    ST_LEAD   = 3'd3,
    ST_DATA   = 3'd4,
    ST_PAD    = 3'd5
  } ws_state_e;

  function automatic int slot_cycles(longint clk_hz, longint rate_hz);
    return int'((clk_hz + rate_hz / 2) / rate_hz);
  endfunction

  // fraction in percent of a slot, rounded in rate units then scaled to clocks
  function automatic int high_cycles(longint clk_hz, longint rate_hz, longint pct);
    longint units;
    units = (pct * rate_hz + 50) / 100;
    return int'((units * longint'(slot_cycles(clk_hz, rate_hz)) + rate_hz / 2) / rate_hz);
  endfunction

  function automatic int latch_cycles(longint clk_hz, longint latch_hz);
    return int'(clk_hz / latch_hz) + 2;
  endfunction

endpackage

// File: rtl/ws_byte_fetch.sv
module ws_byte_fetch #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             active_i,
  input  logic             load_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic             ready_o,
  output logic [7:0]       byte_o,
  output logic             miss_o
);

  logic [CNT_W-1:0] left_q;
  logic [7:0]       buf_q;
  logic             full_q;
  logic             take;

  // no fetch on a load cycle keeps take and consume exclusive
  assign ready_o = active_i && (left_q != '0) && !full_q && !load_i;
  assign take    = valid_i && ready_o;
  assign miss_o  = load_i && !full_q;
  assign byte_o  = full_q ? buf_q : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
    end else if (frame_start_i) begin
      left_q <= count_i;
      full_q <= 1'b0;
    end else begin
      if (take) begin
        buf_q  <= data_i;
        full_q <= 1'b1;
        left_q <= left_q - 1'b1;
      end
      if (load_i) begin
        full_q <= 1'b0;
        if (!full_q && left_q != '0) left_q <= left_q - 1'b1;
      end
    end
  end

  // R10
  one_at_a_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

endmodule

// File: rtl/ws_bit_shift.sv
module ws_bit_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       shift_i,
  input  logic [7:0] byte_i,
  output logic       msb_o
);

  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= byte_i;
    else if (shift_i) sh_q <= {sh_q[6:0], 1'b0};
  end

  assign msb_o = sh_q[7];

endmodule

// File: rtl/ws_frame_ctrl.sv
module ws_frame_ctrl
  import ws_enc_pkg::*;
#(
  parameter int BIT_CYC   = 63,
  parameter int T0_CYC    = 20,
  parameter int T1_CYC    = 40,
  parameter int LATCH_CYC = 2502,
  parameter int PAD_SLOTS = 2,
  parameter int CNT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             bit_i,
  output ws_state_e        state_o,
  output logic             accept_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             line_o
);

  localparam int CYC_MAX = (LATCH_CYC > BIT_CYC) ? LATCH_CYC : BIT_CYC;
  localparam int CYC_W   = $clog2(CYC_MAX + 1);
  localparam int PAD_W   = (PAD_SLOTS > 1) ? $clog2(PAD_SLOTS) : 1;
  localparam logic [CYC_W-1:0] SLOT_LAST  = CYC_W'(BIT_CYC - 1);
  localparam logic [CYC_W-1:0] LATCH_LAST = CYC_W'(LATCH_CYC - 1);
  localparam logic [CYC_W-1:0] T0_LIM     = CYC_W'(T0_CYC);
  localparam logic [CYC_W-1:0] T1_LIM     = CYC_W'(T1_CYC);
  localparam logic [PAD_W-1:0] PAD_LAST   = PAD_W'(PAD_SLOTS - 1);

  ws_state_e        state_q;
  logic [CYC_W-1:0] cyc_q;
  logic [2:0]       bit_q;
  logic [CNT_W-1:0] rem_q;
  logic [PAD_W-1:0] pad_q;
  logic             slot_end;

  assign slot_end = (cyc_q == SLOT_LAST);
  assign accept_o = (state_q == ST_IDLE) && start_i && (count_i != '0);
  assign load_o   = ((state_q == ST_LEAD) && slot_end) ||
                    ((state_q == ST_DATA) && slot_end && (bit_q == 3'd7) && (rem_q != '0));
  assign shift_o  = (state_q == ST_DATA) && slot_end && (bit_q != 3'd7);
  assign line_o   = (state_q == ST_DATA) && (cyc_q < (bit_i ? T1_LIM : T0_LIM));
  assign state_o  = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UNINIT;
      cyc_q   <= '0;
      bit_q   <= '0;
      rem_q   <= '0;
      pad_q   <= '0;
    end else begin
      unique case (state_q)
        ST_UNINIT: begin
          state_q <= ST_BLANK;
          cyc_q   <= '0;
        end
        ST_BLANK: begin
          if (cyc_q == LATCH_LAST) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        ST_IDLE: begin
          if (accept_o) begin
            state_q <= ST_LEAD;
            cyc_q   <= '0;
            rem_q   <= count_i - 1'b1;
          end
        end
        ST_LEAD: begin
          if (slot_end) begin
            state_q <= ST_DATA;
            cyc_q   <= '0;
            bit_q   <= '0;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (slot_end) begin
            cyc_q <= '0;
            if (bit_q == 3'd7) begin
              bit_q <= '0;
              if (rem_q != '0) begin
                rem_q <= rem_q - 1'b1;
              end else begin
                state_q <= ST_PAD;
                pad_q   <= '0;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        ST_PAD: begin
          if (slot_end) begin
            cyc_q <= '0;
            if (pad_q == PAD_LAST) state_q <= ST_BLANK;
            else                   pad_q   <= pad_q + 1'b1;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        default: state_q <= ST_UNINIT;
      endcase
    end
  end

  // R2
  slot_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_LEAD, ST_DATA, ST_PAD}) |-> (cyc_q <= SLOT_LAST));

  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && start_i) |=> (state_q != ST_LEAD));

endmodule

// File: rtl/ws_led_encoder.sv
module ws_led_encoder
  import ws_enc_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BIT_HZ    = 800_000,
  parameter int T0_PCT    = 32,
  parameter int T1_PCT    = 64,
  parameter int LATCH_HZ  = 20_000,
  parameter int PAD_SLOTS = 2,
  parameter int CNT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_data_i,
  output logic             byte_ready_o,
  output logic             busy_o,
  output logic             tx_active_o,
  output logic             underrun_o,
  output logic             serial_o
);

  localparam int BIT_CYC   = slot_cycles(CLK_HZ, BIT_HZ);
  localparam int T0_CYC    = high_cycles(CLK_HZ, BIT_HZ, T0_PCT);
  localparam int T1_CYC    = high_cycles(CLK_HZ, BIT_HZ, T1_PCT);
  localparam int LATCH_CYC = latch_cycles(CLK_HZ, LATCH_HZ);

  ws_state_e  state;
  logic       accept, load, shift, line, msb, miss;
  logic [7:0] next_byte;
  logic       serial_q, underrun_q;

  ws_frame_ctrl #(
    .BIT_CYC  (BIT_CYC),
    .T0_CYC   (T0_CYC),
    .T1_CYC   (T1_CYC),
    .LATCH_CYC(LATCH_CYC),
    .PAD_SLOTS(PAD_SLOTS),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .count_i (byte_count_i),
    .bit_i   (msb),
    .state_o (state),
    .accept_o(accept),
    .load_o  (load),
    .shift_o (shift),
    .line_o  (line)
  );

  ws_byte_fetch #(.CNT_W(CNT_W)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(accept),
    .count_i      (byte_count_i),
    .active_i     (tx_active_o),
    .load_i       (load),
    .valid_i      (byte_valid_i),
    .data_i       (byte_data_i),
    .ready_o      (byte_ready_o),
    .byte_o       (next_byte),
    .miss_o       (miss)
  );

  ws_bit_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .byte_i (next_byte),
    .msb_o  (msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serial_q   <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      serial_q <= line;
      if (accept)    underrun_q <= 1'b0;
      else if (miss) underrun_q <= 1'b1;
    end
  end

  assign serial_o    = serial_q;
  assign underrun_o  = underrun_q;
  assign busy_o      = (state != ST_IDLE);
  assign tx_active_o = (state inside {ST_LEAD, ST_DATA, ST_PAD});

  // R6
  line_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_DATA && $past(state) != ST_DATA) |-> !serial_o);

  // R8
  zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && byte_count_i == '0) |=> !busy_o);

  // R11
  underrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(tx_active_o));

  // R7
  tx_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_o |-> busy_o);

endmodule

// File: tb/tb_ws_led_encoder.sv
`timescale 1ns/1ps
module tb_ws_led_encoder;

  localparam int BIT   = (50_000_000 + 400_000) / 800_000;
  localparam int T0    = (256_000 * BIT + 400_000) / 800_000;
  localparam int T1    = (512_000 * BIT + 400_000) / 800_000;
  localparam int LATCH = 50_000_000 / 20_000 + 2;
  localparam int PAD   = 2;
  localparam int NVEC  = 6;

  // {count, supplied, b0, b1, b2}
  localparam logic [39:0] VEC [NVEC] = '{
    40'h01_01_A5_00_00,
    40'h03_03_FF_00_81,
    40'h02_02_3C_C3_00,
    40'h01_00_FF_00_00,
    40'h03_01_F0_0F_AA,
    40'h02_02_01_80_00
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] count = '0;
  logic        valid = 1'b0;
  logic [7:0]  data = '0;
  logic        ready, busy, tx, underrun, serial;

  int tests = 0;
  int fails = 0;
  int sup;
  logic [7:0] bytes [3];

  always #10 clk = ~clk;

  ws_led_encoder dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .byte_count_i(count),
    .byte_valid_i(valid),
    .byte_data_i (data),
    .byte_ready_o(ready),
    .busy_o      (busy),
    .tx_active_o (tx),
    .underrun_o  (underrun),
    .serial_o    (serial)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_w(input int k);
    int bi;
    bi = k / 8;
    if (bi >= sup || bi > 2) return T0;
    return bytes[bi][7 - (k % 8)] ? T1 : T0;
  endfunction

  task automatic run_frame(input int vi);
    int nb, n, idx, nrise, nfall, bad_w, bad_p, first_rise, last_rise, tx_drop, busy_drop, s;
    logic hs, prev_s;
    nb = int'(VEC[vi][39:32]);
    sup = int'(VEC[vi][31:24]);
    bytes[0] = VEC[vi][23:16];
    bytes[1] = VEC[vi][15:8];
    bytes[2] = VEC[vi][7:0];
    n = 0; idx = 0; nrise = 0; nfall = 0; bad_w = 0; bad_p = 0;
    first_rise = -1; last_rise = 0; tx_drop = -1; busy_drop = -1;
    hs = 1'b0; prev_s = 1'b0;
    @(posedge clk); #2;
    start = 1'b1;
    count = 16'(nb);
    while (busy_drop < 0 && n < 20000) begin
      @(negedge clk);
      n++;
      if (n == 2) start = 1'b0;
      // R9: stray strobe mid-frame
      if (n == 300) begin start = 1'b1; count = 16'd5; end
      if (n == 301) begin start = 1'b0; count = 16'(nb); end
      if (hs) idx++;
      valid = (idx < sup);
      data  = (idx < 3) ? bytes[idx] : 8'h00;
      hs    = valid && ready;
      if (serial && !prev_s) begin
        if (nrise == 0) first_rise = n;
        else if (n - last_rise != BIT) bad_p++;
        last_rise = n;
        nrise++;
      end
      if (!serial && prev_s) begin
        if (n - last_rise != exp_w(nfall)) bad_w++;
        nfall++;
      end
      prev_s = serial;
      if (n >= 2 && tx_drop < 0 && !tx) tx_drop = n;
      if (n >= 2 && !busy) busy_drop = n;
    end
    valid = 1'b0;
    s = 1 + 8 * nb + PAD;
    chk($sformatf("R4 pulse count v%0d", vi), nfall, 8 * nb);
    chk($sformatf("R3 pulse widths v%0d", vi), bad_w, 0);
    chk($sformatf("R2 slot period v%0d", vi), bad_p, 0);
    chk($sformatf("R5 lead slot v%0d", vi), first_rise, BIT + 3);
    chk($sformatf("R6 R9 tx end v%0d", vi), tx_drop, s * BIT + 2);
    chk($sformatf("R6 R7 busy end v%0d", vi), busy_drop, s * BIT + LATCH + 2);
    chk($sformatf("R10 bytes taken v%0d", vi), idx, sup);
    chk($sformatf("R11 underrun v%0d", vi), int'(underrun), int'(sup < nb));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, bad;
    // R1: reset values
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 1);
    chk("R1 tx in reset", int'(tx), 0);
    chk("R1 serial in reset", int'(serial), 0);
    chk("R1 underrun in reset", int'(underrun), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    n = 0;
    bad = 0;
    while (busy && n < 10000) begin
      @(negedge clk);
      n++;
      if (tx || serial) bad++;
    end
    chk("R1 blank length", n, LATCH + 2);
    chk("R1 R7 quiet while blanking", bad, 0);

    for (int v = 0; v < NVEC; v++) run_frame(v);

    // R8: zero count ignored in idle
    @(posedge clk); #2;
    start = 1'b1;
    count = 16'd0;
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i == 3) start = 1'b0;
      if (busy || tx || ready || serial) bad++;
    end
    chk("R8 zero count ignored", bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule